// File: doc/BRIEF.md
# Strap-Configured Dual-Clock FIFO

This block is a first-in first-out buffer with independent write and read clocks, a 9-bit data path and a registered output. Its four status outputs are all active low: full, almost full, empty and almost empty. The almost flags compare the current fill level against two offset values, which can be reloaded at run time. An active-low output enable either shows the output register or leaves the data output undriven.

A single write-side pin has two possible roles. The role is chosen by the level this pin has while reset is held low. If the pin is held high, it acts as a second write enable, so several buffers can be chained to give a deeper buffer. If the pin is held low, it acts as a load strobe for the two offset values. A read needs both read enables asserted. Writes stop while the buffer is full, and reads stop while it is empty.

Each pointer crosses to the other clock domain as Gray code through two flops. As a result, a flag that depends on the other side's activity clears a little late, but never early.

The reset is synchronous and must stay low for at least two edges of each clock. The depth must be a power of two between 512 and 65536.

Top module: `cfg_sync_fifo`

## Requirements
- R1: While rst_n is low, both pointers return to the first location and the output register becomes all zeros. The empty offset returns to EMPTY_OFS_DEF and the full offset to FULL_OFS_DEF (7 by default).
- R2: While rst_n is low, full_n and afull_n read 1 and empty_n and aempty_n read 0.
- R3: The mode is set by the level of wen2_ld at the last write-clock edge with rst_n low. A level of 1 selects dual-enable mode. A level of 0 selects offset-load mode, in which a cycle with wen1_n low and wen2_ld low stores no data word.
- R4: In dual-enable mode, a word is stored on a write-clock edge only when wen1_n is 0 and wen2_ld is 1. A cycle with wen2_ld at 0 stores nothing and loads no offset.
- R5: In offset-load mode, wen1_n low with wen2_ld high stores a word. wen1_n low with wen2_ld low loads the next offset part in this fixed order: empty offset bits [7:0], empty offset bits [AW-1:8], full offset bits [7:0], full offset bits [AW-1:8]. The order then wraps to the first part. A low part is taken from din[7:0] and a high part from din[AW-9:0], where AW = log2(DEPTH).
- R6: On a read-clock edge, the next word moves into the output register only when ren1_n and ren2_n are both 0. Otherwise the output register keeps its value.
- R7: A write attempted while full_n is 0 stores nothing. A read attempted while empty_n is 0 leaves the output register and the read pointer unchanged.
- R8: full_n and afull_n update on the first write-clock edge after a write. empty_n and aempty_n update on the first read-clock edge after a read. A change made in the other domain reaches a flag two edges of the observing clock later. With coincident clocks, a write at edge k first clears empty_n after edge k+2.
- R9: aempty_n is 0 when occupancy is at or below the empty offset. afull_n is 0 when free space (DEPTH minus occupancy) is at or below the full offset.
- R10: With oe_n at 1, dout is high-impedance. With oe_n at 0, dout shows the output register.
- R11: Words leave in the order they were stored, across any number of pointer wrap-arounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous reset, active low, held for at least two edges of each clock |
| wen1_n | input | 1 | Write enable 1, active low |
| wen2_ld | input | 1 | Mode strap at reset, then second write enable (high active) or offset-load strobe (low active) |
| din | input | DATA_W | Write data or offset part |
| ren1_n | input | 1 | Read enable 1, active low |
| ren2_n | input | 1 | Read enable 2, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | DATA_W | Output register, or high-impedance |
| full_n | output | 1 | Full flag, active low, write-clock domain |
| afull_n | output | 1 | Almost-full flag, active low, write-clock domain |
| empty_n | output | 1 | Empty flag, active low, read-clock domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read-clock domain |

## Verification
The bench runs both clocks from one source, so every latency is fixed.

- A stored word, a loaded offset or a popped word shows on the full-side flags, the almost-empty threshold or dout right after the same edge.
- A write reaches empty_n and aempty_n only after two more read edges.
- A read reaches full_n and afull_n only after two more write edges.

The reference model keeps each pointer together with its two-edge-delayed copy. It compares every output at the falling edge following each rising edge. The directed checks wait for exactly these delays, for example empty_n is checked low after edges k and k+1 and high after k+2.

// File: rtl/cfg_sync_fifo_pkg.sv
package cfg_sync_fifo_pkg;

    typedef enum logic {
        WMODE_DUAL_EN   = 1'b0,
        WMODE_OFS_LOAD  = 1'b1
    } wmode_e;

    // Offset part selector; the sequence is behaviour, do not reorder
    typedef enum logic [1:0] {
        OSEL_EMPTY_LO = 2'd0,
        OSEL_EMPTY_HI = 2'd1,
        OSEL_FULL_LO  = 2'd2,
        OSEL_FULL_HI  = 2'd3
    } osel_e;

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/cfg_sync_fifo_sync2.sv
module cfg_sync_fifo_sync2 #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/cfg_sync_fifo_mem.sv
module cfg_sync_fifo_mem #(
    parameter int DATA_W = 9,
    parameter int AW     = 12
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] ram [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            ram[waddr] <= wdata;
        end
    end

    assign rdata = ram[raddr];
endmodule

// File: rtl/cfg_sync_fifo_wr_ctl.sv
module cfg_sync_fifo_wr_ctl
    import cfg_sync_fifo_pkg::*;
#(
    parameter int AW            = 12,
    parameter int EMPTY_OFS_DEF = 7,
    parameter int FULL_OFS_DEF  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic [7:0]    ld_byte,
    input  logic [AW:0]   rd_gray_sync,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW:0]   wr_bin,
    output logic [AW:0]   wr_gray,
    output logic [AW-1:0] empty_ofs,
    output logic          full_n,
    output logic          afull_n
);
    localparam int PW    = AW + 1;
    localparam int HI_W  = AW - 8;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        wmode_e        mode;
        osel_e         osel;
        logic [AW-1:0] eofs;
        logic [AW-1:0] fofs;
        logic [AW:0]   wbin;
        logic [AW:0]   wgray;
    } st_t;

    st_t st_d, st_q;

    logic [PW-1:0] rd_bin_s;
    logic [PW-1:0] used;
    logic [PW-1:0] free;
    logic          is_full;
    logic          wr_go;
    logic          ld_go;

    always_comb begin
        rd_bin_s = PW'(gray_to_bin(32'(rd_gray_sync)));
        used     = st_q.wbin - rd_bin_s;
        free     = PW'(DEPTH) - used;
        is_full  = (used == PW'(DEPTH));
        wr_go    = !wen1_n && wen2_ld && !is_full;
        ld_go    = (st_q.mode == WMODE_OFS_LOAD) && !wen1_n && !wen2_ld;

        st_d = st_q;
        if (wr_go) begin
            st_d.wbin = st_q.wbin + 1'b1;
        end
        st_d.wgray = st_d.wbin ^ (st_d.wbin >> 1);

        if (ld_go) begin
            case (st_q.osel)
                OSEL_EMPTY_LO: st_d.eofs[7:0]    = ld_byte;
                OSEL_EMPTY_HI: st_d.eofs[AW-1:8] = ld_byte[HI_W-1:0];
                OSEL_FULL_LO:  st_d.fofs[7:0]    = ld_byte;
                OSEL_FULL_HI:  st_d.fofs[AW-1:8] = ld_byte[HI_W-1:0];
                default: ;
            endcase
            st_d.osel = osel_e'(st_q.osel + 2'd1);
        end

        if (!rst_n) begin
            st_d      = '0;
            st_d.mode = wen2_ld ? WMODE_DUAL_EN : WMODE_OFS_LOAD;
            st_d.osel = OSEL_EMPTY_LO;
            st_d.eofs = AW'(EMPTY_OFS_DEF);
            st_d.fofs = AW'(FULL_OFS_DEF);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mem_we    = wr_go && rst_n;
    assign mem_waddr = st_q.wbin[AW-1:0];
    assign wr_bin    = st_q.wbin;
    assign wr_gray   = st_q.wgray;
    assign empty_ofs = st_q.eofs;
    assign full_n    = rst_n ? !is_full : 1'b1;
    assign afull_n   = rst_n ? !(free <= {1'b0, st_q.fofs}) : 1'b1;
endmodule

// File: rtl/cfg_sync_fifo_rd_ctl.sv
module cfg_sync_fifo_rd_ctl
    import cfg_sync_fifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int AW     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic [AW:0]       wr_gray_sync,
    input  logic [AW-1:0]     empty_ofs,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [AW-1:0]     mem_raddr,
    output logic [AW:0]       rd_bin,
    output logic [AW:0]       rd_gray,
    output logic [DATA_W-1:0] dout_reg,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [AW:0]       rbin;
        logic [AW:0]       rgray;
        logic [DATA_W-1:0] dout;
    } st_t;

    st_t st_d, st_q;

    logic [PW-1:0] wr_bin_s;
    logic [PW-1:0] used;
    logic          is_empty;
    logic          rd_go;

    always_comb begin
        wr_bin_s = PW'(gray_to_bin(32'(wr_gray_sync)));
        used     = wr_bin_s - st_q.rbin;
        is_empty = (used == '0);
        rd_go    = !ren1_n && !ren2_n && !is_empty;

        st_d = st_q;
        if (rd_go) begin
            st_d.dout = mem_rdata;
            st_d.rbin = st_q.rbin + 1'b1;
        end
        st_d.rgray = st_d.rbin ^ (st_d.rbin >> 1);

        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mem_raddr = st_q.rbin[AW-1:0];
    assign rd_bin    = st_q.rbin;
    assign rd_gray   = st_q.rgray;
    assign dout_reg  = st_q.dout;
    assign empty_n   = rst_n ? !is_empty : 1'b0;
    assign aempty_n  = rst_n ? !(used <= {1'b0, empty_ofs}) : 1'b0;
endmodule

// File: rtl/cfg_sync_fifo.sv
module cfg_sync_fifo #(
    parameter int DATA_W        = 9,
    parameter int DEPTH         = 4096,
    parameter int EMPTY_OFS_DEF = 7,
    parameter int FULL_OFS_DEF  = 7
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wen1_n,
    input  logic              wen2_ld,
    input  logic [DATA_W-1:0] din,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              full_n,
    output logic              afull_n,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int AW = $clog2(DEPTH);

    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [AW-1:0]     mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [AW:0]       wr_bin;
    logic [AW:0]       wr_gray;
    logic [AW:0]       rd_bin;
    logic [AW:0]       rd_gray;
    logic [AW:0]       wr_gray_s;
    logic [AW:0]       rd_gray_s;
    logic [AW-1:0]     empty_ofs;
    logic [DATA_W-1:0] dout_reg;

    cfg_sync_fifo_wr_ctl #(
        .AW(AW), .EMPTY_OFS_DEF(EMPTY_OFS_DEF), .FULL_OFS_DEF(FULL_OFS_DEF)
    ) u_wr (
        .clk(wclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
        .ld_byte(din[7:0]), .rd_gray_sync(rd_gray_s),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .wr_bin(wr_bin), .wr_gray(wr_gray),
        .empty_ofs(empty_ofs), .full_n(full_n), .afull_n(afull_n)
    );

    cfg_sync_fifo_rd_ctl #(.DATA_W(DATA_W), .AW(AW)) u_rd (
        .clk(rclk), .rst_n(rst_n), .ren1_n(ren1_n), .ren2_n(ren2_n),
        .wr_gray_sync(wr_gray_s), .empty_ofs(empty_ofs), .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr), .rd_bin(rd_bin), .rd_gray(rd_gray),
        .dout_reg(dout_reg), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    cfg_sync_fifo_sync2 #(.W(AW + 1)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .async_i(wr_gray), .sync_o(wr_gray_s)
    );

    cfg_sync_fifo_sync2 #(.W(AW + 1)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .async_i(rd_gray), .sync_o(rd_gray_s)
    );

    cfg_sync_fifo_mem #(.DATA_W(DATA_W), .AW(AW)) u_mem (
        .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    assign dout = oe_n ? {DATA_W{1'bz}} : dout_reg;
endmodule

// File: rtl/cfg_sync_fifo_chk.sv
module cfg_sync_fifo_chk #(
    parameter int PW     = 13,
    parameter int DATA_W = 9
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst_n,
    input logic              ren1_n,
    input logic              ren2_n,
    input logic              full_n,
    input logic              afull_n,
    input logic              empty_n,
    input logic              aempty_n,
    input logic [PW-1:0]     wr_bin,
    input logic [PW-1:0]     rd_bin,
    input logic [PW-1:0]     wr_gray,
    input logic [DATA_W-1:0] dout_reg
);
    always @(posedge wclk) begin
        if (!rst_n) begin
            p_reset_wflags_r2: assert (full_n && afull_n)
                else $error("write-side flags active during reset");
        end
    end

    always @(posedge rclk) begin
        if (!rst_n) begin
            p_reset_rflags_r2: assert (!empty_n && !aempty_n)
                else $error("read-side flags released during reset");
        end
    end

    p_out_clear_r1: assert property (@(posedge rclk) disable iff (!rst_n)
        $rose(rst_n) |-> (dout_reg == '0));

    p_no_overflow_r7: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |=> $stable(wr_bin));

    p_no_underflow_r7: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |=> $stable(rd_bin));

    p_out_hold_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        (ren1_n || ren2_n) |=> $stable(dout_reg));

    p_gray_step_r8: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    p_afull_with_full_r9: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    p_aempty_with_empty_r9: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);
endmodule

bind cfg_sync_fifo cfg_sync_fifo_chk #(.PW(AW + 1), .DATA_W(DATA_W)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
    .wr_bin(wr_bin), .rd_bin(rd_bin), .wr_gray(wr_gray), .dout_reg(dout_reg)
);

// File: tb/cfg_sync_fifo_bench.sv
module cfg_sync_fifo_bench;
    localparam int DW    = 9;
    localparam int DEPTH = 512;
    localparam int AW    = $clog2(DEPTH);
    localparam int HI_W  = AW - 8;

    logic          clk = 1'b0;
    logic          rst_n, wen1_n, wen2_ld, ren1_n, ren2_n, oe_n;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          full_n, afull_n, empty_n, aempty_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cfg_sync_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_cfg_sync_fifo (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
        .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .dout(dout),
        .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    // Reference model
    int mq[$];
    int wcnt, rcnt, wd1, wd2, rd1, rd2;
    int eofs, fofs, osel, mdout, reads_done;
    bit mdual;
    int used_w, used_r;
    bit wgo, lgo, rgo;

    always @(posedge clk) begin
        if (!rst_n) begin
            mdual = wen2_ld;
            mq.delete();
            wcnt = 0; rcnt = 0; wd1 = 0; wd2 = 0; rd1 = 0; rd2 = 0;
            eofs = 7; fofs = 7; osel = 0; mdout = 0;
        end else begin
            used_w = wcnt - rd2;
            used_r = wd2 - rcnt;
            wgo = !wen1_n && wen2_ld && (used_w != DEPTH);
            lgo = !mdual && !wen1_n && !wen2_ld;
            rgo = !ren1_n && !ren2_n && (used_r != 0);
            wd2 = wd1; wd1 = wcnt; rd2 = rd1; rd1 = rcnt;
            if (wgo) begin
                mq.push_back(int'(din));
                wcnt++;
            end
            if (lgo) begin
                case (osel)
                    0: eofs = (eofs & 32'h100) | int'(din[7:0]);
                    1: eofs = (eofs & 32'hFF) | (int'(din[HI_W-1:0]) << 8);
                    2: fofs = (fofs & 32'h100) | int'(din[7:0]);
                    default: fofs = (fofs & 32'hFF) | (int'(din[HI_W-1:0]) << 8);
                endcase
                osel = (osel + 1) % 4;
            end
            if (rgo) begin
                mdout = mq.pop_front();
                rcnt++;
                reads_done++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int ur, uw;
        bit e_empty, e_aempty, e_full, e_afull;
        ur = wd2 - rcnt;
        uw = wcnt - rd2;
        e_empty  = rst_n ? (ur != 0) : 1'b0;
        e_aempty = rst_n ? !(ur <= eofs) : 1'b0;
        e_full   = rst_n ? (uw != DEPTH) : 1'b1;
        e_afull  = rst_n ? !((DEPTH - uw) <= fofs) : 1'b1;
        chk(empty_n == e_empty, "R8 empty_n", int'(empty_n), int'(e_empty));
        chk(aempty_n == e_aempty, "R9 aempty_n", int'(aempty_n), int'(e_aempty));
        chk(full_n == e_full, "R8 full_n", int'(full_n), int'(e_full));
        chk(afull_n == e_afull, "R9 afull_n", int'(afull_n), int'(e_afull));
        if (!oe_n) begin
            chk(dout == DW'(mdout), "R11 dout order", int'(dout), mdout);
        end else if (mdout != 0) begin
            chk(dout !== DW'(mdout), "R10 dout released", int'(dout), mdout);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int rd0;
        rst_n = 1'b0; wen1_n = 1'b1; wen2_ld = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
        oe_n = 1'b0; din = '0;
        repeat (3) tick();
        chk(full_n && afull_n, "R2 full flags high in reset", int'({full_n, afull_n}), 3);
        chk(!empty_n && !aempty_n, "R2 empty flags low in reset", int'({empty_n, aempty_n}), 0);
        chk(dout == 0, "R1 output register cleared", int'(dout), 0);
        rst_n = 1'b1;
        tick();
        chk(dout == 0 && !empty_n, "R1 first location after reset", int'(dout), 0);

        // Flag latency across domains (R8)
        wen1_n = 1'b0; din = 9'h0AA; tick(); wen1_n = 1'b1;
        chk(!empty_n, "R8 empty_n after edge k", int'(empty_n), 0);
        tick();
        chk(!empty_n, "R8 empty_n after edge k+1", int'(empty_n), 0);
        tick();
        chk(empty_n, "R8 empty_n after edge k+2", int'(empty_n), 1);

        // Dual-enable mode: second enable low stores nothing (R4)
        wen1_n = 1'b0; wen2_ld = 1'b0; din = 9'h155; repeat (3) tick();
        wen1_n = 1'b1; wen2_ld = 1'b1; repeat (3) tick();
        ren1_n = 1'b0; ren2_n = 1'b0; repeat (2) tick(); ren1_n = 1'b1; ren2_n = 1'b1;
        chk(dout == 9'h0AA, "R4 blocked write left no word", int'(dout), 'h0AA);
        chk(!empty_n, "R7 read on empty ignored", int'(empty_n), 0);

        // Both read enables required (R6)
        wen1_n = 1'b0; din = 9'h1C3; tick(); wen1_n = 1'b1; repeat (3) tick();
        ren1_n = 1'b0; repeat (2) tick();
        chk(dout == 9'h0AA, "R6 hold with ren2_n high", int'(dout), 'h0AA);
        ren1_n = 1'b1; ren2_n = 1'b0; tick();
        chk(dout == 9'h0AA, "R6 hold with ren1_n high", int'(dout), 'h0AA);
        ren1_n = 1'b0; tick(); ren1_n = 1'b1; ren2_n = 1'b1;
        chk(dout == 9'h1C3, "R6 both enables read", int'(dout), 'h1C3);

        // Output enable (R10)
        oe_n = 1'b1; tick();
        chk(dout !== 9'h1C3, "R10 dout released with oe_n high", int'(dout), 'h1C3);
        oe_n = 1'b0; tick();
        chk(dout == 9'h1C3, "R10 dout shown with oe_n low", int'(dout), 'h1C3);

        // Fill past full, then drain (R7, R11)
        wen1_n = 1'b0;
        for (int i = 0; i < DEPTH + 4; i++) begin
            din = DW'(i * 37 + 5);
            tick();
        end
        wen1_n = 1'b1; repeat (3) tick();
        chk(!full_n, "R7 full reached", int'(full_n), 0);
        rd0 = reads_done;
        ren1_n = 1'b0; ren2_n = 1'b0;
        for (int i = 0; i < DEPTH + 4; i++) tick();
        ren1_n = 1'b1; ren2_n = 1'b1;
        chk(reads_done - rd0 == DEPTH, "R7 writes while full dropped", reads_done - rd0, DEPTH);
        chk(dout == DW'((DEPTH - 1) * 37 + 5), "R11 last word in order",
            int'(dout), int'(DW'((DEPTH - 1) * 37 + 5)));

        // Streaming across several wraps (R11)
        wen1_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
        for (int i = 0; i < 1500; i++) begin
            din = DW'(i * 11 + 3);
            tick();
        end
        wen1_n = 1'b1; repeat (6) tick();
        ren1_n = 1'b1; ren2_n = 1'b1;
        chk(!empty_n, "R11 stream drained", int'(empty_n), 0);
        chk(dout == DW'(1499 * 11 + 3), "R11 stream last word", int'(dout), int'(DW'(1499 * 11 + 3)));

        // Offset-load mode (R3, R5, R9)
        rst_n = 1'b0; wen2_ld = 1'b0; repeat (3) tick();
        rst_n = 1'b1; tick();
        wen1_n = 1'b0;
        din = 9'd3; tick();
        din = 9'd0; tick();
        din = 9'd5; tick();
        din = 9'd0; tick();
        wen1_n = 1'b1; wen2_ld = 1'b1; repeat (3) tick();
        chk(!empty_n, "R3 load cycles store no word", int'(empty_n), 0);
        wen1_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            din = DW'(i + 20);
            tick();
        end
        wen1_n = 1'b1; repeat (3) tick();
        chk(!aempty_n, "R9 occupancy 3 at empty offset 3", int'(aempty_n), 0);
        wen1_n = 1'b0; din = 9'd40; tick(); wen1_n = 1'b1; repeat (3) tick();
        chk(aempty_n, "R5 loaded empty offset 3 (occupancy 4)", int'(aempty_n), 1);
        wen1_n = 1'b0; wen2_ld = 1'b0; din = 9'd10; tick();
        wen1_n = 1'b1; wen2_ld = 1'b1;
        chk(!aempty_n, "R5 fifth load wraps to empty low part", int'(aempty_n), 0);
        wen1_n = 1'b0;
        for (int i = 0; i < DEPTH - 10; i++) begin
            din = DW'(i);
            tick();
        end
        wen1_n = 1'b1;
        chk(afull_n, "R9 free space 6 above full offset 5", int'(afull_n), 1);
        wen1_n = 1'b0; tick(); wen1_n = 1'b1;
        chk(!afull_n, "R9 free space 5 at full offset 5", int'(afull_n), 0);
        tick();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule